// File: doc/BRIEF.md
# Pulse-per-second external time synchroniser

This block aligns a local time-of-day counter with a once-per-second pulse that arrives together with a 48-bit seconds value on an external time bus. The pulse input is resynchronised into the local clock domain, and only a low-to-high transition counts as an event. At each event, a two-bit overwrite policy decides whether the local counter is reloaded and where the new seconds value comes from: the external bus seconds or a software-held seconds value. A signed correction in units of 2^-16 ns is folded into the reloaded value.

At every event the block also records how far the external time, taken as the bus seconds with zero nanoseconds, sits from the local time. The result is a signed 32-bit value in 2^-16 ns units. A sticky status bit marks each event and drives an interrupt line through an enable. Software clears the status bit by writing 1 to it. A single enable input gates the whole function. The block produces load strobes and values for the counter. It does not decode the framing of the external bus.

Top module: `pps_sync`

## Requirements
- R1: While `ext_en` is 0, a pulse on `pps_in` produces no load strobe, leaves `irq_sts` unchanged and leaves `phase_diff` unchanged.
- R2: `pps_in` passes through two synchroniser stages. A low-to-high transition yields exactly one event. The event's `ld_stb` is high for one cycle after the third rising clock edge that samples `pps_in` high, and it stays low while the pulse is held high.
- R3: With `ovr_mode` 2'b00 (no overwrite) or 2'b11 (reserved), an event never raises `ld_stb`.
- R4: With `ovr_mode` 2'b01, an event raises `ld_stb`, and the seconds base for the load is `ext_sec`.
- R5: With `ovr_mode` 2'b10, an event raises `ld_stb`, and the seconds base for the load is `sw_sec`.
- R6: `load_ofs` is a signed two's-complement value in 2^-16 ns units. When it is non-negative, `ld_sec` is the base, `ld_ns` is `load_ofs[31:16]` and `ld_frac` is `load_ofs[15:0]`. When it is negative, `ld_sec` is the base minus 1 (modulo 2^48), and `{ld_ns, ld_frac}` equals 10^9 * 2^16 + `load_ofs`.
- R7: Every event, in any mode, updates `phase_diff` on the same edge as `ld_stb`. The new value is (`ext_sec` - `loc_sec`) * 10^9 * 2^16 - (`loc_ns` * 2^16 + `loc_frac`), saturated to the signed 32-bit range. Between events, `phase_diff` holds its value.
- R8: An event sets `irq_sts`. A cycle with `sts_wr` high and `sts_wdata` 1 clears it. A cycle with `sts_wr` high and `sts_wdata` 0 leaves it unchanged.
- R9: When a clear write and an event fall in the same cycle, `irq_sts` stays set.
- R10: `irq` is high exactly when both `irq_sts` and `irq_en` are high.
- R11: After reset, `ld_stb`, `irq_sts`, `irq` and `phase_diff` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_en | input | 1 | Global enable for the external bus function |
| ovr_mode | input | 2 | Overwrite policy: 00 none, 01 bus seconds, 10 software seconds, 11 reserved (none) |
| pps_in | input | 1 | Asynchronous pulse-per-second input |
| ext_sec | input | 48 | Seconds value on the external bus |
| sw_sec | input | 48 | Software-held seconds value |
| load_ofs | input | 32 | Signed load correction, 2^-16 ns units |
| loc_sec | input | 48 | Local counter seconds |
| loc_ns | input | 30 | Local counter nanoseconds |
| loc_frac | input | 16 | Local counter sub-nanosecond fraction |
| irq_en | input | 1 | Interrupt enable |
| sts_wr | input | 1 | Status write strobe |
| sts_wdata | input | 1 | Status write data; 1 clears |
| ld_stb | output | 1 | One-cycle load strobe to the local counter |
| ld_sec | output | 48 | Seconds value to load |
| ld_ns | output | 30 | Nanoseconds value to load |
| ld_frac | output | 16 | Fraction value to load |
| phase_diff | output | 32 | Signed external-minus-local difference, 2^-16 ns units |
| irq_sts | output | 1 | Sticky event status |
| irq | output | 1 | Masked interrupt |

## Verification
A software clear of the status bit can coincide with a new synchronised event. To provoke this, the bench raises the pulse, waits for two sampling edges, and then drives the clear write so that it is present at the edge where the event registers. Right after that edge, `irq_sts` must read 1. Before this case, the bench shows that the same write alone clears the bit and that a write of 0 leaves it set, so that the result of the collision test carries meaning.

// File: rtl/pps_sync_pkg.sv
package pps_sync_pkg;

   typedef enum logic [1:0] {
      OVR_NONE = 2'b00,
      OVR_EXT  = 2'b01,
      OVR_SW   = 2'b10,
      OVR_RSVD = 2'b11
   } ovr_mode_e;

   localparam logic [63:0] NS_PER_SEC = 64'd1_000_000_000;

endpackage

// File: rtl/pps_sync_edge.sv
module pps_sync_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic pps_in,
   output logic evt
);
   localparam int MSB = SYNC_STAGES - 1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_stages
         $error("pps_sync_edge: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [MSB:0] sync_q;
   logic         prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[MSB-1:0], pps_in};
         prev_q <= sync_q[MSB];
      end
   end

   assign evt = en & sync_q[MSB] & ~prev_q;

   // R2: one event per rising transition
   a_r2_single_event: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> !evt);

   // R1: nothing happens while disabled
   a_r1_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> !evt);

endmodule

// File: rtl/pps_sync_load.sv
module pps_sync_load
   import pps_sync_pkg::*;
#(
   parameter int SEC_W  = 48,
   parameter int NS_W   = 30,
   parameter int FRAC_W = 16,
   parameter int OFS_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt,
   input  ovr_mode_e         mode,
   input  logic [SEC_W-1:0]  ext_sec,
   input  logic [SEC_W-1:0]  sw_sec,
   input  logic [OFS_W-1:0]  ofs,
   output logic              ld_stb,
   output logic [SEC_W-1:0]  ld_sec,
   output logic [NS_W-1:0]   ld_ns,
   output logic [FRAC_W-1:0] ld_frac
);
   localparam int INT_W = OFS_W - FRAC_W;
   localparam int PAD_W = NS_W + 1 - INT_W;
   localparam logic [NS_W:0] ONE_SEC_NS = (NS_W+1)'(NS_PER_SEC);

   generate
      if (OFS_W <= FRAC_W) begin : g_bad_ofs
         $error("pps_sync_load: OFS_W must exceed FRAC_W");
      end
      if (INT_W >= NS_W) begin : g_bad_ns
         $error("pps_sync_load: offset integer part must be narrower than NS_W");
      end
   endgenerate

   logic              do_ld;
   logic              ofs_neg;
   logic [SEC_W-1:0]  base_sec;
   logic [NS_W:0]     ofs_ns;
   logic [NS_W:0]     ns_val;
   logic [SEC_W-1:0]  sec_val;

   always_comb begin
      do_ld    = evt && (mode == OVR_EXT || mode == OVR_SW);
      base_sec = (mode == OVR_EXT) ? ext_sec : sw_sec;
      ofs_neg  = ofs[OFS_W-1];
      ofs_ns   = {{PAD_W{ofs[OFS_W-1]}}, ofs[OFS_W-1:FRAC_W]};
      ns_val   = ofs_neg ? (ONE_SEC_NS + ofs_ns) : ofs_ns;
      sec_val  = ofs_neg ? (base_sec - SEC_W'(1)) : base_sec;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ld_stb  <= 1'b0;
         ld_sec  <= '0;
         ld_ns   <= '0;
         ld_frac <= '0;
      end else begin
         ld_stb <= do_ld;
         if (do_ld) begin
            ld_sec  <= sec_val;
            ld_ns   <= ns_val[NS_W-1:0];
            ld_frac <= ofs[FRAC_W-1:0];
         end
      end
   end

   // R3: loads only under the two overwrite policies
   a_r3_mode_guard: assert property (@(posedge clk) disable iff (!rst_n)
      ld_stb |-> ($past(mode) == OVR_EXT || $past(mode) == OVR_SW));

   // R6: loaded nanoseconds stay below one second
   a_r6_ns_range: assert property (@(posedge clk) disable iff (!rst_n)
      ld_stb |-> (ld_ns < ONE_SEC_NS[NS_W-1:0]));

   // R2: a load strobe lasts one cycle
   a_r2_strobe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      ld_stb |=> !ld_stb);

endmodule

// File: rtl/pps_sync_phase.sv
module pps_sync_phase
   import pps_sync_pkg::*;
#(
   parameter int SEC_W    = 48,
   parameter int NS_W     = 30,
   parameter int FRAC_W   = 16,
   parameter int DIFF_W   = 32,
   parameter bit SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt,
   input  logic [SEC_W-1:0]  ext_sec,
   input  logic [SEC_W-1:0]  loc_sec,
   input  logic [NS_W-1:0]   loc_ns,
   input  logic [FRAC_W-1:0] loc_frac,
   output logic [DIFF_W-1:0] phase_diff
);
   localparam int SUB_W = NS_W + FRAC_W;
   localparam logic signed [63:0] SEC_UNITS = signed'(NS_PER_SEC << FRAC_W);
   localparam logic signed [63:0] LIM_HI = (64'sd1 <<< (DIFF_W - 1)) - 64'sd1;
   localparam logic signed [63:0] LIM_LO = -(64'sd1 <<< (DIFF_W - 1));

   generate
      if (DIFF_W > 62 || DIFF_W < 2) begin : g_bad_diff
         $error("pps_sync_phase: DIFF_W out of range");
      end
      if (SUB_W > 62) begin : g_bad_sub
         $error("pps_sync_phase: NS_W + FRAC_W too wide");
      end
   endgenerate

   logic signed [SEC_W:0] sec_delta;
   logic signed [63:0]    loc_sub;
   logic signed [63:0]    base;
   logic signed [63:0]    raw;
   logic                  far;
   logic [DIFF_W-1:0]     diff_d;

   always_comb begin
      sec_delta = $signed({1'b0, ext_sec}) - $signed({1'b0, loc_sec});
      loc_sub   = {{(64-SUB_W){1'b0}}, loc_ns, loc_frac};
      far       = (sec_delta > 1) || (sec_delta < -1);
      if (sec_delta == 1)       base = SEC_UNITS;
      else if (sec_delta == -1) base = -SEC_UNITS;
      else                      base = 64'sd0;
      raw = base - loc_sub;
   end

   generate
      if (SATURATE) begin : g_sat
         logic signed [63:0] clamped;
         always_comb begin
            if (far)                clamped = sec_delta[SEC_W] ? LIM_LO : LIM_HI;
            else if (raw > LIM_HI)  clamped = LIM_HI;
            else if (raw < LIM_LO)  clamped = LIM_LO;
            else                    clamped = raw;
            diff_d = clamped[DIFF_W-1:0];
         end
      end else begin : g_wrap
         assign diff_d = raw[DIFF_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) phase_diff <= '0;
      else if (evt) phase_diff <= diff_d;
   end

   // R7: difference register holds between events
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !evt |=> $stable(phase_diff));

endmodule

// File: rtl/pps_sync.sv
module pps_sync
   import pps_sync_pkg::*;
#(
   parameter int SEC_W       = 48,
   parameter int NS_W        = 30,
   parameter int FRAC_W      = 16,
   parameter int OFS_W       = 32,
   parameter int DIFF_W      = 32,
   parameter int SYNC_STAGES = 2,
   parameter bit SATURATE    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_en,
   input  logic [1:0]        ovr_mode,
   input  logic              pps_in,
   input  logic [SEC_W-1:0]  ext_sec,
   input  logic [SEC_W-1:0]  sw_sec,
   input  logic [OFS_W-1:0]  load_ofs,
   input  logic [SEC_W-1:0]  loc_sec,
   input  logic [NS_W-1:0]   loc_ns,
   input  logic [FRAC_W-1:0] loc_frac,
   input  logic              irq_en,
   input  logic              sts_wr,
   input  logic              sts_wdata,
   output logic              ld_stb,
   output logic [SEC_W-1:0]  ld_sec,
   output logic [NS_W-1:0]   ld_ns,
   output logic [FRAC_W-1:0] ld_frac,
   output logic [DIFF_W-1:0] phase_diff,
   output logic              irq_sts,
   output logic              irq
);
   logic evt;
   logic clr_req;

   pps_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (ext_en),
      .pps_in (pps_in),
      .evt    (evt)
   );

   pps_sync_load #(
      .SEC_W(SEC_W), .NS_W(NS_W), .FRAC_W(FRAC_W), .OFS_W(OFS_W)
   ) u_load (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (evt),
      .mode    (ovr_mode_e'(ovr_mode)),
      .ext_sec (ext_sec),
      .sw_sec  (sw_sec),
      .ofs     (load_ofs),
      .ld_stb  (ld_stb),
      .ld_sec  (ld_sec),
      .ld_ns   (ld_ns),
      .ld_frac (ld_frac)
   );

   pps_sync_phase #(
      .SEC_W(SEC_W), .NS_W(NS_W), .FRAC_W(FRAC_W),
      .DIFF_W(DIFF_W), .SATURATE(SATURATE)
   ) u_phase (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt        (evt),
      .ext_sec    (ext_sec),
      .loc_sec    (loc_sec),
      .loc_ns     (loc_ns),
      .loc_frac   (loc_frac),
      .phase_diff (phase_diff)
   );

   assign clr_req = sts_wr & sts_wdata;

   always_ff @(posedge clk) begin
      if (!rst_n)       irq_sts <= 1'b0;
      else if (evt)     irq_sts <= 1'b1;
      else if (clr_req) irq_sts <= 1'b0;
   end

   assign irq = irq_sts & irq_en;

   // R8: an event sets the status bit
   a_r8_set: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> irq_sts);

   // R8: a lone clear write of 1 clears it
   a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req && !evt) |=> !irq_sts);

   // R8: without event or clear the bit holds
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!evt && !clr_req) |=> $stable(irq_sts));

   // R9: event wins over a same-cycle clear
   a_r9_collision: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && clr_req) |=> irq_sts);

   // R7: load strobe and difference update share the event
   a_r7_same_edge: assert property (@(posedge clk) disable iff (!rst_n)
      ld_stb |-> $past(evt));

endmodule

// File: tb/pps_sync_tb_top.sv
module pps_sync_tb_top;

   localparam longint SEC_UNITS = 64'd1_000_000_000 * 65536;
   localparam longint D_HI = 64'sd2147483647;
   localparam longint D_LO = -64'sd2147483648;

   typedef struct packed {
      logic [1:0]  mode;
      logic [47:0] ext;
      logic [47:0] sw;
      logic [31:0] ofs;
      logic [47:0] lsec;
      logic [29:0] lns;
      logic [15:0] lfrac;
      logic        stb;
   } vec_t;

   localparam int NVEC = 7;
   localparam vec_t VECS [NVEC] = '{
      '{2'b01, 48'd100, 48'd9, 32'h0001_8000, 48'd100, 30'd0, 16'h0020, 1'b1},
      '{2'b10, 48'd7, 48'd5000, 32'hFFFF_FFFF, 48'd7, 30'd3, 16'h0000, 1'b1},
      '{2'b00, 48'd101, 48'd1, 32'h0000_0000, 48'd100, 30'd999999990, 16'h0000, 1'b0},
      '{2'b11, 48'd50, 48'd1, 32'h0002_0000, 48'd60, 30'd5, 16'h0000, 1'b0},
      '{2'b01, 48'h0000_FFFF_FFFF, 48'd0, 32'hFFFD_0000, 48'h0000_FFFF_FFFF, 30'd0, 16'h0000, 1'b1},
      '{2'b10, 48'd0, 48'd0, 32'h8000_0000, 48'd0, 30'd40000, 16'h0000, 1'b1},
      '{2'b01, 48'd12, 48'd3, 32'h7FFF_FFFF, 48'd11, 30'd0, 16'h0000, 1'b1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ext_en = 1'b0;
   logic [1:0]  ovr_mode = 2'b00;
   logic        pps_in = 1'b0;
   logic [47:0] ext_sec = '0;
   logic [47:0] sw_sec = '0;
   logic [31:0] load_ofs = '0;
   logic [47:0] loc_sec = '0;
   logic [29:0] loc_ns = '0;
   logic [15:0] loc_frac = '0;
   logic        irq_en = 1'b0;
   logic        sts_wr = 1'b0;
   logic        sts_wdata = 1'b0;
   logic        ld_stb;
   logic [47:0] ld_sec;
   logic [29:0] ld_ns;
   logic [15:0] ld_frac;
   logic [31:0] phase_diff;
   logic        irq_sts;
   logic        irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   pps_sync dut_i (
      .clk(clk), .rst_n(rst_n), .ext_en(ext_en), .ovr_mode(ovr_mode),
      .pps_in(pps_in), .ext_sec(ext_sec), .sw_sec(sw_sec), .load_ofs(load_ofs),
      .loc_sec(loc_sec), .loc_ns(loc_ns), .loc_frac(loc_frac), .irq_en(irq_en),
      .sts_wr(sts_wr), .sts_wdata(sts_wdata), .ld_stb(ld_stb), .ld_sec(ld_sec),
      .ld_ns(ld_ns), .ld_frac(ld_frac), .phase_diff(phase_diff),
      .irq_sts(irq_sts), .irq(irq)
   );

   task automatic chk(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic longint exp_diff(input logic [47:0] e, input logic [47:0] ls,
                                       input logic [29:0] ns, input logic [15:0] fr);
      longint sd = longint'({16'd0, e}) - longint'({16'd0, ls});
      longint v;
      if (sd > 1) return D_HI;
      if (sd < -1) return D_LO;
      v = sd * SEC_UNITS - (longint'(ns) * 65536 + longint'(fr));
      if (v > D_HI) return D_HI;
      if (v < D_LO) return D_LO;
      return v;
   endfunction

   // one pulse; samples just after the third edge that sees it high
   task automatic pulse_and_sample(output logic s_stb, output logic s_stb_next);
      @(negedge clk) pps_in = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk) s_stb = ld_stb;
      @(negedge clk) s_stb_next = ld_stb;
      repeat (2) @(negedge clk);
      pps_in = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic s1, s2;
      logic [47:0] base, e_sec;
      longint sub, whole, last_diff;

      repeat (4) @(negedge clk);
      irq_en = 1'b1;
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk("R11 ld_stb", longint'(ld_stb), 0);
      chk("R11 irq_sts", longint'(irq_sts), 0);
      chk("R11 irq", longint'(irq), 0);
      chk("R11 phase_diff", longint'(phase_diff), 0);

      ext_en = 1'b1;
      for (int i = 0; i < NVEC; i++) begin
         ovr_mode = VECS[i].mode;
         ext_sec = VECS[i].ext;
         sw_sec = VECS[i].sw;
         load_ofs = VECS[i].ofs;
         loc_sec = VECS[i].lsec;
         loc_ns = VECS[i].lns;
         loc_frac = VECS[i].lfrac;
         pulse_and_sample(s1, s2);
         // R2 / R3 / R4 / R5 strobe presence and width
         chk($sformatf("R3 R4 R5 vec%0d ld_stb", i), longint'(s1), longint'(VECS[i].stb));
         chk($sformatf("R2 vec%0d strobe one cycle", i), longint'(s2), 0);
         if (VECS[i].stb) begin
            base = (VECS[i].mode == 2'b01) ? VECS[i].ext : VECS[i].sw;
            sub = longint'(signed'(VECS[i].ofs));
            if (sub >= 0) begin
               e_sec = base;
               whole = sub;
            end else begin
               e_sec = base - 48'd1;
               whole = SEC_UNITS + sub;
            end
            chk($sformatf("R6 vec%0d ld_sec", i), longint'(ld_sec), longint'(e_sec));
            chk($sformatf("R6 vec%0d ld_ns", i), longint'(ld_ns), whole / 65536);
            chk($sformatf("R6 vec%0d ld_frac", i), longint'(ld_frac), whole % 65536);
         end
         chk($sformatf("R7 vec%0d phase_diff", i), longint'(signed'(phase_diff)),
             exp_diff(VECS[i].ext, VECS[i].lsec, VECS[i].lns, VECS[i].lfrac));
         chk($sformatf("R8 vec%0d irq_sts", i), longint'(irq_sts), 1);
      end
      last_diff = longint'(signed'(phase_diff));

      // R8 write 0 has no effect, write 1 clears; R10 masking
      @(negedge clk) begin sts_wr = 1'b1; sts_wdata = 1'b0; end
      @(negedge clk) sts_wr = 1'b0;
      chk("R8 write0 keeps", longint'(irq_sts), 1);
      chk("R10 irq enabled", longint'(irq), 1);
      irq_en = 1'b0;
      @(negedge clk);
      chk("R10 irq masked", longint'(irq), 0);
      irq_en = 1'b1;
      @(negedge clk) begin sts_wr = 1'b1; sts_wdata = 1'b1; end
      @(negedge clk) sts_wr = 1'b0;
      chk("R8 write1 clears", longint'(irq_sts), 0);
      chk("R10 irq after clear", longint'(irq), 0);

      // R1 disabled: no strobe, no status, no difference update
      ext_en = 1'b0;
      ovr_mode = 2'b01;
      ext_sec = 48'd300;
      loc_sec = 48'd300;
      loc_ns = 30'd77;
      pulse_and_sample(s1, s2);
      chk("R1 no strobe", longint'(s1), 0);
      chk("R1 status untouched", longint'(irq_sts), 0);
      chk("R1 diff untouched", longint'(signed'(phase_diff)), last_diff);
      ext_en = 1'b1;

      // R8 set again, then R9 collision
      pulse_and_sample(s1, s2);
      chk("R8 event sets", longint'(irq_sts), 1);
      @(negedge clk) pps_in = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk) begin sts_wr = 1'b1; sts_wdata = 1'b1; end
      @(posedge clk);
      @(negedge clk) sts_wr = 1'b0;
      chk("R9 collision keeps status", longint'(irq_sts), 1);
      chk("R9 event strobe present", longint'(ld_stb), 1);
      pps_in = 1'b0;
      repeat (4) @(negedge clk);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule